// File: doc/BRIEF.md
# Cipher Descriptor Sequencer

This block sits between a descriptor fetcher and a cipher/hash datapath. It takes one descriptor at a time, as a control word and an index word. It pulls out the two byte counts, the packet boundary flags, the mode bits and the two engine selectors, and checks them for format errors. A clean descriptor is dispatched to the datapath with a one-cycle start pulse. The datapath then answers with a done or a hash-error strobe. A programmable cycle counter turns a missing answer into a timeout.

Each descriptor gets exactly one write-back pulse carrying a 2-bit status. Once a packet fails, the rest of its descriptors are consumed without being dispatched, up to and including the one that closes the packet. Timeout and hash faults set sticky interrupt flags, which are cleared by writing a one. Before the first descriptor of a new packet goes out, every engine receives a one-cycle reset.

Top module: `cdesc_seq`

## Requirements
- R1: The control word is decoded as output byte count [31:21], input byte count [20:10], start-of-packet [9], end-of-packet [8], XOR mode [4] and last-of-type [3]. The other bits, including the status field [2:1], are ignored. At dispatch the counts and the three flag bits appear on the engine outputs.
- R2: The index word carries the hash selector in [6:4] and the cipher selector in [2:0]. A value of 0 means pass-through and 1 to 6 pick a key set. Both selectors are forwarded at dispatch. A selector of 7 gives status 11 with no dispatch.
- R3: A byte count of 1 to 7, in either count, gives status 11 and no dispatch. Counts of 0 and of 8 to 2047 are accepted.
- R4: When the hash selector is non-zero and the input count is below 8, the descriptor gets status 11 with no dispatch.
- R5: When the hash selector is non-zero and end-of-packet is set, the output count must equal the digest length or the status is 11. The digest length is 20 for hash sets 4, 5 and 6 and 16 for sets 1, 2 and 3.
- R6: A dispatched descriptor with start-of-packet set pulses eng_rst for one cycle, in the cycle just before eng_start. A dispatched descriptor without that flag pulses no reset.
- R7: Status encoding: 00 done, 01 timeout, 10 hash engine error, 11 format error. eng_herr takes precedence over eng_done in the same cycle.
- R8: If neither done nor a hash error arrives in the tmo_limit+1 waiting cycles after the start pulse, the status is 01. wb_valid rises tmo_limit+2 cycles after the eng_start cycle.
- R9: After a non-zero status on a descriptor without end-of-packet, the following descriptors are consumed without reset or dispatch, each written back with that same status. This continues up to and including the first one with end-of-packet set.
- R10: A timeout sets irq_flags[0] and a hash error sets irq_flags[1]. The flags stay set until a one is written to the matching bit of irq_clr. irq is the OR of the two flags.
- R11: desc_ready is low from the cycle after a dispatched descriptor is accepted until its write-back. Descriptors that are skipped or rejected leave it high.
- R12: After reset, desc_ready is high, and eng_rst, eng_start, wb_valid, irq_flags and irq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer can take a descriptor |
| desc_ctrl | input | 32 | Control word |
| desc_idx | input | 32 | Index word |
| tmo_limit | input | TMO_W | Timeout window in cycles |
| eng_rst | output | 1 | One-cycle reset to all engines |
| eng_start | output | 1 | One-cycle dispatch strobe |
| eng_in_bytes | output | 11 | Input byte count of the descriptor |
| eng_out_bytes | output | 11 | Output byte count of the descriptor |
| eng_enc_sel | output | 3 | Cipher key-set selector |
| eng_hash_sel | output | 3 | Hash key-set selector |
| eng_xor | output | 1 | XOR mode select |
| eng_last | output | 1 | Last data of this type |
| eng_eop | output | 1 | End of packet |
| eng_done | input | 1 | Datapath finished the descriptor |
| eng_herr | input | 1 | Hash engine fault |
| wb_valid | output | 1 | Status write-back strobe |
| wb_err | output | 2 | Status code |
| irq_clr | input | 2 | Write-one-to-clear for the flags |
| irq_flags | output | 2 | Sticky flags: [0] timeout, [1] hash |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the skip chain. It needs a runtime fault or a format error in the middle of a packet, followed by more descriptors of that packet, some of which look valid or even carry a fresh start-of-packet. Only then can the bench see the block refuse to dispatch them, repeat the stored status and resume exactly after end-of-packet. The random stimulus draws the boundary flags independently and often picks illegal counts and reserved selectors. It also makes the datapath respond with a late done, a hash fault, both strobes at once, or silence. Long runs of faulted packets therefore occur often. Directed sequences add the digest-length cases, a short timeout window with exact timing, and the clearing of the flags.

// File: rtl/cdesc_pkg.sv
package cdesc_pkg;

  localparam int CNT_W = 11;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic [CNT_W-1:0] out_cnt;
    logic [CNT_W-1:0] in_cnt;
    logic             sop;
    logic             eop;
    logic             xor_m;
    logic             last;
    logic [SEL_W-1:0] enc_sel;
    logic [SEL_W-1:0] hash_sel;
  } desc_t;

  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_TMO  = 2'b01,
    ST_HASH = 2'b10,
    ST_FMT  = 2'b11
  } status_e;

  function automatic desc_t split_words(input logic [31:0] c, input logic [31:0] x);
    desc_t d;
    d.out_cnt  = c[31:21];
    d.in_cnt   = c[20:10];
    d.sop      = c[9];
    d.eop      = c[8];
    d.xor_m    = c[4];
    d.last     = c[3];
    d.hash_sel = x[6:4];
    d.enc_sel  = x[2:0];
    return d;
  endfunction

  // counts between 1 and 7 are not allowed
  function automatic logic short_count(input logic [CNT_W-1:0] n);
    return (n != '0) && (n < CNT_W'(8));
  endfunction

  function automatic logic [CNT_W-1:0] digest_len(input logic [SEL_W-1:0] sel,
                                                  input logic [7:0] long_mask);
    return long_mask[sel] ? CNT_W'(20) : CNT_W'(16);
  endfunction

endpackage

// File: rtl/cdesc_check.sv
module cdesc_check
  import cdesc_pkg::*;
#(
  parameter logic [7:0] LONG_SETS = 8'b0111_0000
) (
  input  desc_t d,
  output logic  bad
);
  localparam logic [SEL_W-1:0] SEL_RSV = '1;

  logic cnt_bad, sel_bad, hash_short, digest_bad;

  always_comb begin
    cnt_bad    = short_count(d.in_cnt) || short_count(d.out_cnt);
    sel_bad    = (d.enc_sel == SEL_RSV) || (d.hash_sel == SEL_RSV);
    hash_short = (d.hash_sel != '0) && (d.in_cnt < CNT_W'(8));
    digest_bad = (d.hash_sel != '0) && d.eop &&
                 (d.out_cnt != digest_len(d.hash_sel, LONG_SETS));
    bad = cnt_bad || sel_bad || hash_short || digest_bad;
  end

  always_comb begin
    assert_short_in_R3: assert (!(d.in_cnt == CNT_W'(5)) || bad);
    assert_rsv_sel_R2:  assert (!(d.hash_sel == SEL_RSV) || bad);
  end

endmodule

// File: rtl/cdesc_timer.sv
module cdesc_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= limit;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

endmodule

// File: rtl/cdesc_seq.sv
module cdesc_seq
  import cdesc_pkg::*;
#(
  parameter int         TMO_W     = 16,
  parameter logic [7:0] LONG_SETS = 8'b0111_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [31:0]      desc_ctrl,
  input  logic [31:0]      desc_idx,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             eng_rst,
  output logic             eng_start,
  output logic [10:0]      eng_in_bytes,
  output logic [10:0]      eng_out_bytes,
  output logic [2:0]       eng_enc_sel,
  output logic [2:0]       eng_hash_sel,
  output logic             eng_xor,
  output logic             eng_last,
  output logic             eng_eop,
  input  logic             eng_done,
  input  logic             eng_herr,
  output logic             wb_valid,
  output logic [1:0]       wb_err,
  input  logic [1:0]       irq_clr,
  output logic [1:0]       irq_flags,
  output logic             irq
);
  typedef enum logic [1:0] {S_IDLE, S_RST, S_GO, S_WAIT} state_e;

  state_e  state;
  desc_t   dec, cur;
  logic    bad, expired;
  logic    skip_q;
  status_e skip_code;

  // named events for the checks
  logic acc, hash_evt, done_evt, tmo_evt, fin_evt;
  status_e fin_code;

  logic unused_rsv;
  assign unused_rsv = ^{desc_ctrl[7:5], desc_ctrl[2:0], desc_idx[31:7], desc_idx[3]};

  assign dec = split_words(desc_ctrl, desc_idx);

  cdesc_check #(.LONG_SETS(LONG_SETS)) u_check (.d(dec), .bad(bad));

  cdesc_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(eng_start), .run(state == S_WAIT),
    .limit(tmo_limit), .expired(expired)
  );

  assign desc_ready = (state == S_IDLE);
  assign acc        = desc_valid && desc_ready;
  assign eng_rst    = (state == S_RST);
  assign eng_start  = (state == S_GO);

  assign hash_evt = (state == S_WAIT) && eng_herr;
  assign done_evt = (state == S_WAIT) && eng_done && !eng_herr;
  assign tmo_evt  = expired && !eng_done && !eng_herr;
  assign fin_evt  = hash_evt || done_evt || tmo_evt;
  assign fin_code = hash_evt ? ST_HASH : (tmo_evt ? ST_TMO : ST_OK);

  assign eng_in_bytes  = cur.in_cnt;
  assign eng_out_bytes = cur.out_cnt;
  assign eng_enc_sel   = cur.enc_sel;
  assign eng_hash_sel  = cur.hash_sel;
  assign eng_xor       = cur.xor_m;
  assign eng_last      = cur.last;
  assign eng_eop       = cur.eop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= '0;
      skip_q    <= 1'b0;
      skip_code <= ST_OK;
      wb_valid  <= 1'b0;
      wb_err    <= 2'b00;
    end else begin
      wb_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (acc) begin
          cur <= dec;
          if (skip_q) begin
            wb_valid <= 1'b1;
            wb_err   <= skip_code;
            if (dec.eop) skip_q <= 1'b0;
          end else if (bad) begin
            wb_valid <= 1'b1;
            wb_err   <= ST_FMT;
            if (!dec.eop) begin
              skip_q    <= 1'b1;
              skip_code <= ST_FMT;
            end
          end else begin
            state <= dec.sop ? S_RST : S_GO;
          end
        end
        S_RST: state <= S_GO;
        S_GO:  state <= S_WAIT;
        S_WAIT: if (fin_evt) begin
          state    <= S_IDLE;
          wb_valid <= 1'b1;
          wb_err   <= fin_code;
          if (fin_code != ST_OK && !cur.eop) begin
            skip_q    <= 1'b1;
            skip_code <= fin_code;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flags <= 2'b00;
    else        irq_flags <= (irq_flags & ~irq_clr) | {hash_evt, tmo_evt};
  end

  assign irq = |irq_flags;

  assert_rst_before_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> eng_start);
  assert_skip_no_dispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && skip_q) |=> (!eng_rst && !eng_start && wb_valid));
  assert_tmo_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (wb_valid && wb_err == 2'b01 && irq_flags[0]));
  assert_hash_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hash_evt |=> (wb_valid && wb_err == 2'b10 && irq_flags[1]));
  assert_one_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_rst, eng_start, desc_ready}));
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[0] && !irq_clr[0]) |=> irq_flags[0]);

endmodule

// File: tb/sim_cdesc_seq.sv
module sim_cdesc_seq;
  localparam int L_RAND = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0;
  logic [31:0] desc_ctrl = '0, desc_idx = '0;
  logic [15:0] tmo_limit = 16'(L_RAND);
  logic        eng_done = 1'b0, eng_herr = 1'b0;
  logic [1:0]  irq_clr = 2'b00;
  logic        desc_ready, eng_rst, eng_start, eng_xor, eng_last, eng_eop, wb_valid, irq;
  logic [10:0] eng_in_bytes, eng_out_bytes;
  logic [2:0]  eng_enc_sel, eng_hash_sel;
  logic [1:0]  wb_err, irq_flags;

  int compared = 0, mismatched = 0;
  int cycles = 0;
  bit m_skip = 0;
  int m_code = 0;
  int m_flags = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  cdesc_seq u0 (.*);

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent statement of the format rules (R2..R5)
  function automatic bit fmt_bad(logic [31:0] c, logic [31:0] x);
    int oc = int'(c >> 21) & 2047;
    int ic = int'(c >> 10) & 2047;
    int hs = int'(x >> 4) & 7;
    int es = int'(x) & 7;
    bit eop = c[8];
    int dg = (hs >= 4) ? 20 : 16;
    if (oc > 0 && oc < 8) return 1;
    if (ic > 0 && ic < 8) return 1;
    if (hs == 7 || es == 7) return 1;
    if (hs != 0 && ic < 8) return 1;
    if (hs != 0 && eop && oc != dg) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mk_ctrl(int oc, int ic, bit sop, bit eop, bit xm, bit last);
    return (32'(oc) << 21) | (32'(ic) << 10) | (32'(sop) << 9) | (32'(eop) << 8) |
           (32'(xm) << 4) | (32'(last) << 3);
  endfunction

  // kind: 0 done, 1 hash error, 2 silent, 3 done and hash error together
  task automatic run_desc(logic [31:0] c, logic [31:0] x, int kind, int d, int lim);
    bit sop = c[9], eop = c[8];
    bit disp, got = 0;
    int e_err, n_rst = 0, n_start = 0, since = -1, wb_at = -1, act_err = -1;
    int s_in = 0, s_out = 0, s_enc = 0, s_hash = 0, s_flags = 0;
    string tg;
    if (m_skip) begin
      disp = 0; e_err = m_code; tg = "R9";
      if (eop) m_skip = 0;
    end else if (fmt_bad(c, x)) begin
      disp = 0; e_err = 3; tg = "R3";
      if (!eop) begin m_skip = 1; m_code = 3; end
    end else begin
      disp = 1; tg = "R7";
      e_err = (kind == 0) ? 0 : (kind == 2 ? 1 : 2);
      if (e_err == 1) m_flags |= 1;
      if (e_err == 2) m_flags |= 2;
      if (e_err != 0 && !eop) begin m_skip = 1; m_code = e_err; end
    end
    @(negedge clk);
    desc_valid = 1; desc_ctrl = c; desc_idx = x;
    @(negedge clk);
    desc_valid = 0;
    chk("R11 ready after accept", int'(desc_ready), int'(!disp));
    for (int k = 0; k < 200 && !got; k++) begin
      eng_done = 0; eng_herr = 0;
      if (eng_rst) begin
        n_rst++;
        if (n_start != 0) chk("R6 reset after start", 1, 0);
      end
      if (eng_start) begin
        n_start++; since = 0;
        s_in = int'(eng_in_bytes); s_out = int'(eng_out_bytes);
        s_enc = int'(eng_enc_sel); s_hash = int'(eng_hash_sel);
        s_flags = {int'(eng_xor), int'(eng_last), int'(eng_eop)};
      end else if (since >= 0) since++;
      if (wb_valid) begin
        got = 1; act_err = int'(wb_err); wb_at = since;
      end else begin
        if (since == d && since > 0 && kind != 2) begin
          eng_done = (kind == 0 || kind == 3);
          eng_herr = (kind == 1 || kind == 3);
        end
        @(negedge clk);
      end
    end
    eng_done = 0; eng_herr = 0;
    chk({tg, " status"}, act_err, e_err);
    chk("R9 dispatch count", n_start, int'(disp));
    chk("R6 engine reset count", n_rst, int'(disp && sop));
    if (disp) begin
      chk("R1 in count", s_in, int'(c[20:10]));
      chk("R1 out count", s_out, int'(c[31:21]));
      chk("R1 xor/last/eop", s_flags, {int'(c[4]), int'(c[3]), int'(c[8])});
      chk("R2 cipher sel", s_enc, int'(x[2:0]));
      chk("R2 hash sel", s_hash, int'(x[6:4]));
      if (kind == 2) chk("R8 timeout latency", wb_at, lim + 2);
    end
    chk("R10 flags", int'(irq_flags), m_flags);
    chk("R10 irq", int'(irq), int'(m_flags != 0));
  endtask

  task automatic clear_flags(logic [1:0] v);
    @(negedge clk); irq_clr = v;
    @(negedge clk); irq_clr = 2'b00;
    m_flags &= ~int'(v);
    chk("R10 clear", int'(irq_flags), m_flags);
  endtask

  function automatic int rnd_count();
    int r = int'($urandom % 10);
    if (r == 0) return 0;
    if (r == 1) return 1 + int'($urandom % 7);
    if (r == 2) return 16;
    if (r == 3) return 20;
    return 8 + int'($urandom % 2040);
  endfunction

  function automatic int rnd_sel();
    if ($urandom % 4 != 0) return int'($urandom % 7);
    return int'($urandom % 8);
  endfunction

  initial begin : watchdog
    wait (cycles > 150000);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    int unsigned seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 ready", int'(desc_ready), 1);
    chk("R12 start/rst", int'({eng_start, eng_rst}), 0);
    chk("R12 wb_valid", int'(wb_valid), 0);
    chk("R12 irq", int'({irq_flags, irq}), 0);

    // R1: plain cipher packet, reserved bits and status field set (ignored)
    run_desc(mk_ctrl(64, 32, 1, 0, 1, 0) | 32'h0000_00E7, 32'hFFFF_FF88 | 32'h2, 0, 3, L_RAND);
    run_desc(mk_ctrl(0, 8, 0, 1, 0, 1), 32'h5, 0, 1, L_RAND);
    // R3: illegal count mid packet, then the rest is skipped (R9)
    run_desc(mk_ctrl(16, 16, 1, 0, 0, 0), 32'h1, 0, 2, L_RAND);
    run_desc(mk_ctrl(5, 16, 0, 0, 0, 0), 32'h1, 0, 2, L_RAND);
    run_desc(mk_ctrl(16, 16, 1, 0, 0, 0), 32'h1, 0, 2, L_RAND);
    run_desc(mk_ctrl(16, 16, 0, 1, 0, 0), 32'h1, 0, 2, L_RAND);
    run_desc(mk_ctrl(0, 0, 1, 1, 0, 0), 32'h0, 0, 1, L_RAND);
    // R4: hash with zero input
    run_desc(mk_ctrl(16, 0, 1, 1, 0, 0), 32'h10, 0, 1, L_RAND);
    // R5: digest lengths
    run_desc(mk_ctrl(16, 64, 1, 1, 0, 0), 32'h20, 0, 1, L_RAND);
    run_desc(mk_ctrl(20, 64, 1, 1, 0, 0), 32'h20, 0, 1, L_RAND);
    run_desc(mk_ctrl(20, 64, 1, 1, 0, 0), 32'h50, 0, 1, L_RAND);
    run_desc(mk_ctrl(16, 64, 1, 1, 0, 0), 32'h60, 0, 1, L_RAND);
    // R2: reserved selector
    run_desc(mk_ctrl(16, 16, 1, 1, 0, 0), 32'h7, 0, 1, L_RAND);
    // R7: hash error and done together, then skip with code 10 (R9)
    run_desc(mk_ctrl(0, 64, 1, 0, 0, 0), 32'h10, 3, 2, L_RAND);
    run_desc(mk_ctrl(20, 64, 0, 1, 0, 0), 32'h40, 0, 1, L_RAND);
    clear_flags(2'b10);
    // R8: short timeout window, exact latency
    tmo_limit = 16'd3;
    run_desc(mk_ctrl(32, 32, 1, 1, 0, 0), 32'h3, 2, 0, 3);
    tmo_limit = 16'd0;
    run_desc(mk_ctrl(32, 32, 1, 1, 0, 0), 32'h3, 2, 0, 0);
    tmo_limit = 16'(L_RAND);
    clear_flags(2'b01);

    for (int i = 0; i < 400; i++) begin
      int kr = int'($urandom % 8);
      int kind = (kr < 5) ? 0 : kr - 4;
      logic [31:0] c = mk_ctrl(rnd_count(), rnd_count(), 1'($urandom), 1'($urandom),
                               1'($urandom), 1'($urandom)) | ($urandom & 32'h0000_00E7);
      logic [31:0] x = (32'(rnd_sel()) << 4) | 32'(rnd_sel()) | ($urandom & 32'hFFFF_FF88);
      if (kind == 3 && ($urandom % 2 == 0)) kind = 0;
      run_desc(c, x, kind, 1 + int'($urandom % 8), L_RAND);
      if ($urandom % 8 == 0) clear_flags(2'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule